// File: doc/BRIEF.md
# CAN Transceiver Standby and Wake-Up Controller

This block is the digital mode logic that sits between a CAN protocol controller and the analog front end of a bus transceiver. The host picks between two modes with one select input: low gives normal operation, high gives a low-power standby. In normal mode the host's transmit data drives the bus driver enable, and the receive-data output to the host follows the full-speed differential receiver.

In standby the driver is held off whatever the transmit input does. The receive-data output is then fed from the low-power receiver through a duration filter. Only a dominant level that lasts for the wake time, counted in system-clock cycles, pulls the receive output low. The host sees that low as a wake request. The block never leaves standby by itself: the host must drive the select input low.

The select input and both receiver outputs are asynchronous to the system clock, so each passes through a two-stage synchroniser. Because the select and transmit pads carry pull-ups, all synchroniser stages reset to the high level. A block just out of reset therefore behaves as if the select were high (standby) and the bus were recessive.

Top module: `can_stby_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block is in standby: `drv_en_o` is 0 and `rxd_o` is 1.
- R2: The mode register follows the select input with three cycles of latency: a 0 on `stby_sel_i` selects normal mode, a 1 selects standby.
- R3: In standby, `drv_en_o` is 0 for every value of `txd_i`.
- R4: In normal mode, `drv_en_o` is 1 exactly when `txd_i` is 0 (dominant). A 1 on `txd_i` (recessive) gives 0, with no clock delay.
- R5: In normal mode, `rxd_o` equals the value of `main_rx_i` sampled two clock edges earlier. The value of `lp_rx_i` has no effect on it.
- R6: In standby, `rxd_o` is 1 until `lp_rx_i` has been sampled 0 (dominant) on WAKE_CYC consecutive edges, counting after synchronisation. It goes to 0 on the cycle the count reaches WAKE_CYC. WAKE_CYC is CLK_HZ/1000 × WAKE_US/1000.
- R7: A single 1 (recessive) sample clears the wake count. A dominant run of WAKE_CYC−1 samples never lowers `rxd_o`.
- R8: After a wake, `rxd_o` stays 0 while the synchronised low-power input stays dominant. It returns to 1 one cycle after the first recessive synchronised sample.
- R9: The block stays in standby while `stby_sel_i` is 1, whatever the bus or `txd_i` do, including after a wake request.
- R10: The wake count is held at zero in normal mode. On entry to standby it starts from zero, even if the low-power input was already dominant.
- R11: In standby, `main_rx_i` has no effect on `rxd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_sel_i | input | 1 | Host mode select: 0 normal, 1 standby (pulled high at pad) |
| txd_i | input | 1 | Host transmit data: 0 dominant, 1 recessive (pulled high at pad) |
| main_rx_i | input | 1 | Full-speed receiver output: 0 dominant, 1 recessive |
| lp_rx_i | input | 1 | Low-power receiver output: 0 dominant, 1 recessive |
| drv_en_o | output | 1 | Bus driver enable: 1 drives the bus dominant |
| rxd_o | output | 1 | Receive data to the host; a 0 in standby is a wake request |

## Verification
The bench builds the block with CLK_HZ = 4 MHz and WAKE_US = 5, which gives a wake time of 20 clock cycles in place of the 150,000 that the defaults give. A short wake time lets the bench reach every filter boundary cheaply. It covers runs of exactly WAKE_CYC−1 and WAKE_CYC dominant samples, a run broken by one recessive sample, a wake held for many cycles, and a dominant bus that is already present when standby is entered. Mode changes are driven in both directions while the bus is active, so the synchroniser latency and the rule that standby is never left automatically are compared on every clock.

// File: rtl/can_stby_pkg.sv
package can_stby_pkg;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_STANDBY = 1'b1
    } xcvr_mode_e;

    typedef struct packed {
        logic stby;
        logic main_rx;
        logic lp_rx;
    } async_in_t;

    localparam int ASYNC_W = $bits(async_in_t);

    function automatic int wake_cycles(input int clk_hz, input int wake_us);
        return (clk_hz / 1000) * wake_us / 1000;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/cstb_sync.sv
module cstb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '1;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '1;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cstb_wake_filter.sv
module cstb_wake_filter #(
    parameter int THRESH = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic dom,
    output logic wake
);
    import can_stby_pkg::*;

    localparam int CW = cnt_width(THRESH);
    localparam logic [CW-1:0] TH_V = CW'(THRESH);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !dom) begin
            cnt_q <= '0;
        end else if (cnt_q != TH_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wake = (cnt_q == TH_V);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TH_V);

    assert_recessive_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !dom |=> cnt_q == '0);

    assert_entry_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);

    assert_wake_needs_dom_R8: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(dom));
endmodule

// File: rtl/cstb_mode_ctrl.sv
module cstb_mode_ctrl
    import can_stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stby_sync,
    input  logic       txd,
    input  logic       main_rx_sync,
    input  logic       wake,
    output xcvr_mode_e mode,
    output logic       drv_en,
    output logic       rxd
);
    xcvr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_STANDBY;
        else     mode_q <= stby_sync ? MODE_STANDBY : MODE_NORMAL;
    end

    always_comb begin
        unique case (mode_q)
            MODE_NORMAL: begin
                drv_en = ~txd;
                rxd    = main_rx_sync;
            end
            default: begin
                drv_en = 1'b0;
                rxd    = ~wake;
            end
        endcase
    end

    assign mode = mode_q;

    assert_reset_standby_R1: assert property (@(posedge clk)
        $past(rst) |-> (mode_q == MODE_STANDBY && !drv_en && rxd));

    assert_select_normal_R2: assert property (@(posedge clk) disable iff (rst)
        !stby_sync |=> mode_q == MODE_NORMAL);

    assert_stby_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
        stby_sync |=> !drv_en);

    assert_no_auto_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STANDBY && stby_sync) |=> mode_q == MODE_STANDBY);
endmodule

// File: rtl/can_stby_ctrl.sv
module can_stby_ctrl #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int WAKE_US     = 3000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stby_sel_i,
    input  logic txd_i,
    input  logic main_rx_i,
    input  logic lp_rx_i,
    output logic drv_en_o,
    output logic rxd_o
);
    import can_stby_pkg::*;

    localparam int WAKE_CYC = wake_cycles(CLK_HZ, WAKE_US);

    async_in_t  raw, syn;
    xcvr_mode_e mode;
    logic       wake;

    assign raw.stby    = stby_sel_i;
    assign raw.main_rx = main_rx_i;
    assign raw.lp_rx   = lp_rx_i;

    cstb_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    cstb_wake_filter #(.THRESH(WAKE_CYC)) u_wake (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode == MODE_NORMAL),
        .dom  (!syn.lp_rx),
        .wake (wake)
    );

    cstb_mode_ctrl u_mode (
        .clk          (clk),
        .rst          (rst),
        .stby_sync    (syn.stby),
        .txd          (txd_i),
        .main_rx_sync (syn.main_rx),
        .wake         (wake),
        .mode         (mode),
        .drv_en       (drv_en_o),
        .rxd          (rxd_o)
    );
endmodule

// File: tb/tb_can_stby_ctrl.sv
module tb_can_stby_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 4_000_000;
    localparam int TB_WAKE_US = 5;
    localparam int TH         = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stby_sel = 1'b1, txd = 1'b1, main_rx = 1'b1, lp_rx = 1'b1;
    logic drv_en, rxd;

    int    n_vec = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";

    // reference model state
    bit st_q[$], mr_q[$], lp_q[$];
    bit m_stby;
    int m_run;

    can_stby_ctrl #(.CLK_HZ(TB_CLK_HZ), .WAKE_US(TB_WAKE_US)) dut (
        .clk(clk), .rst(rst), .stby_sel_i(stby_sel), .txd_i(txd),
        .main_rx_i(main_rx), .lp_rx_i(lp_rx), .drv_en_o(drv_en), .rxd_o(rxd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            st_q = '{1, 1}; mr_q = '{1, 1}; lp_q = '{1, 1};
            m_stby = 1; m_run = 0;
        end else begin
            if (m_stby && lp_q[1] == 0) m_run = (m_run >= TH) ? TH : m_run + 1;
            else                         m_run = 0;
            m_stby = st_q[1];
            void'(st_q.pop_back()); st_q.push_front(stby_sel);
            void'(mr_q.pop_back()); mr_q.push_front(main_rx);
            void'(lp_q.pop_back()); lp_q.push_front(lp_rx);
        end
    end

    task automatic tick();
        logic exp_rxd, exp_drv;
        @(posedge clk);
        @(negedge clk);
        #1;
        exp_drv = !m_stby && !txd;
        exp_rxd = m_stby ? !(m_run >= TH) : mr_q[1];
        n_vec++;
        if (drv_en !== exp_drv) begin
            n_bad++;
            $display("FAIL %s drv_en_o actual=%b expected=%b t=%0t", cur_req, drv_en, exp_drv, $time);
        end
        n_vec++;
        if (rxd !== exp_rxd) begin
            n_bad++;
            $display("FAIL %s rxd_o actual=%b expected=%b t=%0t", cur_req, rxd, exp_rxd, $time);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        cur_req = "R1";
        run(4);
        rst = 1'b0;
        run(3);

        cur_req = "R3";            // standby, txd dominant must not drive
        txd = 1'b0; run(5);
        txd = 1'b1; run(2);

        cur_req = "R7";            // one short of wake time, then a broken run
        lp_rx = 1'b0; run(TH - 1);
        lp_rx = 1'b1; run(1);
        lp_rx = 1'b0; run(TH - 1);
        lp_rx = 1'b1; run(4);

        cur_req = "R6";            // exactly the wake time, then held
        lp_rx = 1'b0; run(TH + 6);

        cur_req = "R11";           // main receiver toggling while in standby
        for (int i = 0; i < 6; i++) begin main_rx = i[0]; run(1); end
        main_rx = 1'b1;

        cur_req = "R9";            // no automatic exit, driver stays off
        txd = 1'b0; run(8); txd = 1'b1;

        cur_req = "R8";
        lp_rx = 1'b1; run(4);

        cur_req = "R2";            // enter normal mode
        stby_sel = 1'b0; run(5);

        cur_req = "R4";
        for (int i = 0; i < 8; i++) begin txd = (i % 3 == 0); run(1); end
        txd = 1'b1; run(1);

        cur_req = "R5";
        for (int i = 0; i < 16; i++) begin
            main_rx = ((i * 7) % 5) > 1;
            lp_rx   = i[1];
            run(1);
        end
        main_rx = 1'b1;

        cur_req = "R10";           // bus already dominant on standby entry
        lp_rx = 1'b0; run(TH + 4);
        stby_sel = 1'b1; run(TH + 6);
        lp_rx = 1'b1; run(3);

        cur_req = "R2";            // host brings it back to normal
        stby_sel = 1'b0; run(4);
        main_rx = 1'b0; run(3);
        main_rx = 1'b1; run(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_bad++;
        $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule